// File: doc/BRIEF.md
# Parallel DMA interface register controller

This block is the register and control core of a 16-bit parallel interface board that moves words between an external device and host memory by DMA. The host sees a small register port at byte offsets: a control/status register whose write meaning (commands) differs from its read meaning (status), a data register, a byte pair for an address-modifier and an interrupt vector, a pulse register that sets or clears interrupt enable, a 32-bit DMA address split into low and high halves with separate write and read offsets, and a word-count range register.

Toward the device the block drives three function latches, a one-cycle GO pulse and an output data word. It samples an attention line, three status lines, a parity-error line, an input data word and a cycle-request line. When DMA runs, every cycle request (from the device, or forced by the host) raises `dma_req`. Each acknowledged word advances the address by two bytes with carry into the high half and decrements the range. When the range reaches zero the block raises the end-of-range flag, drops DMA-active so ready returns, and, with interrupts enabled, asserts `irq`. Flags are cleared by writing reset bits. A master clear empties the whole block in one cycle.

Top module: `pdma_regcore`

## Requirements
- R1: After reset the status word (offset 0x00) reads 0x0081 (ready bit 7 and the variant bit 0 set), and `irq`, `dma_req`, `dev_go` and `dev_fn` are all low.
- R2: A control write latches data bits 3..1 into `dev_fn[2:0]` and bit 6 into interrupt enable; status bits 3..1 and bit 6 read them back.
- R3: A write to the pulse register (0x06) with bit 6 set turns interrupt enable on, with only bit 5 set turns it off, with both set turns it on; every other bit has no effect on any register.
- R4: The low address is written at 0x14 and read at 0x18, the high address written at 0x1C and read at 0x20, the range is read/write at 0x16, and the modifier/vector pair at 0x04. A data write at 0x02 drives `dev_dout` and a read there returns `dev_din`, sampled one cycle earlier. Any other even offset, including the write-only ones, reads 0.
- R5: A control write with bit 0 set, while DMA is idle and the range is nonzero, starts DMA (status bit 7 goes low) and gives a one-cycle `dev_go` pulse. Each acknowledged word adds 2 to the 32-bit `dma_addr` with carry from bit 15 into bit 16, and subtracts 1 from the range.
- R6: The acknowledge that takes the range from 1 to 0 sets status bit 15, ends DMA (bit 7 back to 1) and drops `dma_req`. A GO with the range already 0 sets bit 15 at once and leaves DMA idle. Writing control bit 15 clears the flag.
- R7: A control write with bit 8 set while DMA runs raises `dma_req` just as a device cycle request does. The same write while DMA is idle raises nothing.
- R8: A rising edge on `dev_attn` sets status bit 14, and bit 13 shows the sampled line level. Control bit 14 clears the flag, a line held high does not set it again, and an edge that arrives in the same cycle as the clear wins. Status bits 11, 10 and 9 show `dev_stat[2]`, `dev_stat[1]` and `dev_stat[0]`.
- R9: A high sample of `dev_perr` sets status bit 12, which stays set until a control write with bit 13.
- R10: `irq` is high, one cycle after the condition, exactly when interrupt enable is on and the end-of-range or attention flag is set.
- R11: A `dma_berr` or `dma_tmo` while a request is outstanding ends DMA without counting the word and sets status bit 5 or bit 4 respectively. The next GO clears both.
- R12: A control write with bit 12 set clears the function latches, interrupt enable, all flags, the address, the range, the modifier/vector pair and DMA-active in one cycle; the other bits of that write are ignored.
- R13: `dma_dir` equals function latch bit 1 (1 = device to memory, 0 = memory to device).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| h_addr | input | 6 | Host byte offset |
| h_wen | input | 1 | Host write strobe |
| h_wdata | input | 16 | Host write data |
| h_ren | input | 1 | Host read strobe |
| h_rdata | output | 16 | Read data, registered, valid the cycle after `h_ren` |
| dev_fn | output | 3 | Function latches to the device |
| dev_go | output | 1 | One-cycle GO pulse |
| dev_dout | output | 16 | Output data register |
| dev_din | input | 16 | Input data word from the device |
| dev_attn | input | 1 | Attention line |
| dev_stat | input | 3 | Status lines A (bit 2), B, C (bit 0) |
| dev_perr | input | 1 | External parity error |
| dev_cyc | input | 1 | Device cycle request, one word per high cycle |
| dma_req | output | 1 | Word request to memory |
| dma_dir | output | 1 | Transfer direction |
| dma_addr | output | 32 | Current DMA byte address |
| dma_ack | input | 1 | Word done |
| dma_berr | input | 1 | Bus error on the current request |
| dma_tmo | input | 1 | Bus timeout on the current request |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of events can meet in one cycle. A word acknowledge can meet a fresh device cycle request, which must leave `dma_req` high for the next word. An attention edge can meet the host's attention-clear write, and the flag must survive. The bench holds `dev_cyc` high through the acknowledge edge and then checks that the request is still high and the range has dropped by exactly one. It also raises `dev_attn` one edge before the clear write so that the edge and the write reach the flag together, and then expects status bit 14 to read back set.

// File: rtl/pdma_pkg.sv
`timescale 1ns/1ps
package pdma_pkg;
  localparam int W   = 16;
  localparam int HAW = 6;
  localparam int NFN = 3;
  localparam int NST = 3;

  localparam logic [HAW-1:0] OFS_CSR   = 6'h00;
  localparam logic [HAW-1:0] OFS_DAT   = 6'h02;
  localparam logic [HAW-1:0] OFS_AMV   = 6'h04;
  localparam logic [HAW-1:0] OFS_PLS   = 6'h06;
  localparam logic [HAW-1:0] OFS_ALO_W = 6'h14;
  localparam logic [HAW-1:0] OFS_RNG   = 6'h16;
  localparam logic [HAW-1:0] OFS_ALO_R = 6'h18;
  localparam logic [HAW-1:0] OFS_AHI_W = 6'h1C;
  localparam logic [HAW-1:0] OFS_AHI_R = 6'h20;

  // command bit positions (control write)
  localparam int CB_CLR_EOR = 15;
  localparam int CB_CLR_ATT = 14;
  localparam int CB_CLR_PAR = 13;
  localparam int CB_MCLR    = 12;
  localparam int CB_CYC     = 8;
  localparam int CB_IE      = 6;
  localparam int CB_FN_LO   = 1;
  localparam int CB_GO      = 0;

  // pulse register bit positions
  localparam int PB_SET_IE = 6;
  localparam int PB_CLR_IE = 5;
endpackage

// File: rtl/pdma_insync.sv
`timescale 1ns/1ps
module pdma_insync #(
  parameter int DW = 16,
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          attn,
  input  logic          perr,
  input  logic [NS-1:0] stat,
  input  logic [DW-1:0] din,
  output logic          attn_lvl,
  output logic          attn_rise,
  output logic          perr_lvl,
  output logic [NS-1:0] stat_lvl,
  output logic [DW-1:0] din_lvl
);
  logic attn_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      attn_lvl  <= 1'b0;
      attn_prev <= 1'b0;
      perr_lvl  <= 1'b0;
      stat_lvl  <= '0;
      din_lvl   <= '0;
    end else begin
      attn_lvl  <= attn;
      attn_prev <= attn_lvl;
      perr_lvl  <= perr;
      stat_lvl  <= stat;
      din_lvl   <= din;
    end
  end

  assign attn_rise = attn_lvl & ~attn_prev;
endmodule

// File: rtl/pdma_engine.sv
`timescale 1ns/1ps
module pdma_engine #(
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            mclr,
  input  logic            go,
  input  logic            cyc_force,
  input  logic            clr_eor,
  input  logic            dev_cyc,
  input  logic            lo_we,
  input  logic            hi_we,
  input  logic            rng_we,
  input  logic [DW-1:0]   wdata,
  input  logic            ack,
  input  logic            bus_err,
  input  logic            bus_tmo,
  output logic            active,
  output logic            req,
  output logic [2*DW-1:0] addr,
  output logic [DW-1:0]   range,
  output logic            eor,
  output logic            berr_f,
  output logic            tmo_f
);
  localparam int AW = 2 * DW;

  logic          act_q, pend_q, eor_q, berr_q, tmo_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] rng_q;
  logic          fire, new_req, last_word;

  assign fire      = act_q & pend_q;
  assign new_req   = dev_cyc | cyc_force;
  assign last_word = (rng_q == DW'(1));

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
      eor_q  <= 1'b0;
      berr_q <= 1'b0;
      tmo_q  <= 1'b0;
      addr_q <= '0;
      rng_q  <= '0;
    end else begin
      eor_q <= eor_q & ~clr_eor;
      if (!act_q) begin
        if (go) begin
          berr_q <= 1'b0;
          tmo_q  <= 1'b0;
          if (rng_q == '0) begin
            eor_q <= 1'b1;
          end else begin
            act_q  <= 1'b1;
            pend_q <= new_req;
          end
        end
      end else if (fire && (bus_err || bus_tmo)) begin
        act_q  <= 1'b0;
        pend_q <= 1'b0;
        berr_q <= berr_q | bus_err;
        tmo_q  <= tmo_q | bus_tmo;
      end else if (fire && ack) begin
        addr_q <= addr_q + AW'(STEP);
        rng_q  <= rng_q - DW'(1);
        if (last_word) begin
          act_q  <= 1'b0;
          pend_q <= 1'b0;
          eor_q  <= 1'b1;
        end else begin
          pend_q <= new_req;
        end
      end else begin
        pend_q <= pend_q | new_req;
      end
      // host register writes take precedence over the DMA update
      if (lo_we)  addr_q[DW-1:0]  <= wdata;
      if (hi_we)  addr_q[AW-1:DW] <= wdata;
      if (rng_we) rng_q           <= wdata;
    end
  end

  assign active = act_q;
  assign req    = pend_q;
  assign addr   = addr_q;
  assign range  = rng_q;
  assign eor    = eor_q;
  assign berr_f = berr_q;
  assign tmo_f  = tmo_q;

  // R6: a request is only outstanding while DMA runs
  a_r6_req_only_active: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> act_q);

  // R5: the range only moves on an acknowledged word or a host write
  a_r5_range_stable: assert property (@(posedge clk) disable iff (rst)
    (!(fire && ack) && !rng_we && !mclr) |=> $stable(rng_q));
endmodule

// File: rtl/pdma_ctl.sv
`timescale 1ns/1ps
module pdma_ctl #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mclr,
  input  logic          we_csr,
  input  logic [NF-1:0] fn_wr,
  input  logic          ie_wr,
  input  logic          clr_att,
  input  logic          clr_par,
  input  logic          go,
  input  logic          we_pls,
  input  logic          pls_set,
  input  logic          pls_clr,
  input  logic          attn_rise,
  input  logic          perr_lvl,
  input  logic          eor,
  output logic [NF-1:0] fn,
  output logic          ie,
  output logic          attf,
  output logic          perr_f,
  output logic          irq,
  output logic          go_pulse
);
  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      fn       <= '0;
      ie       <= 1'b0;
      attf     <= 1'b0;
      perr_f   <= 1'b0;
      irq      <= 1'b0;
      go_pulse <= 1'b0;
    end else begin
      go_pulse <= go;
      if (we_csr) begin
        fn <= fn_wr;
        ie <= ie_wr;
      end
      if (we_pls) begin
        if (pls_set)      ie <= 1'b1;
        else if (pls_clr) ie <= 1'b0;
      end
      attf   <= (attf & ~clr_att) | attn_rise;
      perr_f <= (perr_f & ~clr_par) | perr_lvl;
      irq    <= ie & (eor | attf);
    end
  end

  // R10: no interrupt one cycle after interrupt enable was off
  a_r10_irq_gate: assert property (@(posedge clk) disable iff (rst)
    !ie |=> !irq);

  // R8: an attention edge always lands in the flag, even against a clear
  a_r8_attf_set: assert property (@(posedge clk) disable iff (rst)
    (attn_rise && !mclr) |=> attf);

  // R12: master clear empties the control state
  a_r12_mclr: assert property (@(posedge clk) disable iff (rst)
    mclr |=> (fn == '0 && !ie && !attf && !perr_f && !irq && !go_pulse));
endmodule

// File: rtl/pdma_regcore.sv
`timescale 1ns/1ps
module pdma_regcore
  import pdma_pkg::*;
#(
  parameter int  STEP       = 2,
  parameter logic VARIANT_ID = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HAW-1:0] h_addr,
  input  logic           h_wen,
  input  logic [W-1:0]   h_wdata,
  input  logic           h_ren,
  output logic [W-1:0]   h_rdata,
  output logic [NFN-1:0] dev_fn,
  output logic           dev_go,
  output logic [W-1:0]   dev_dout,
  input  logic [W-1:0]   dev_din,
  input  logic           dev_attn,
  input  logic [NST-1:0] dev_stat,
  input  logic           dev_perr,
  input  logic           dev_cyc,
  output logic           dma_req,
  output logic           dma_dir,
  output logic [2*W-1:0] dma_addr,
  input  logic           dma_ack,
  input  logic           dma_berr,
  input  logic           dma_tmo,
  output logic           irq
);
  logic we_csr, we_pls, mclr, go, cyc_force;
  logic attn_lvl, attn_rise, perr_lvl;
  logic [NST-1:0] stat_lvl;
  logic [W-1:0]   din_lvl, range, amv_q, rd_mux, status;
  logic active, eor, berr_f, tmo_f, ie, attf, perr_f;

  assign we_csr    = h_wen && (h_addr == OFS_CSR);
  assign we_pls    = h_wen && (h_addr == OFS_PLS);
  assign mclr      = we_csr && h_wdata[CB_MCLR];
  assign go        = we_csr && !mclr && h_wdata[CB_GO];
  assign cyc_force = we_csr && !mclr && h_wdata[CB_CYC];

  pdma_insync #(.DW(W), .NS(NST)) u_insync (
    .clk(clk), .rst(rst), .attn(dev_attn), .perr(dev_perr),
    .stat(dev_stat), .din(dev_din), .attn_lvl(attn_lvl),
    .attn_rise(attn_rise), .perr_lvl(perr_lvl), .stat_lvl(stat_lvl),
    .din_lvl(din_lvl)
  );

  pdma_engine #(.DW(W), .STEP(STEP)) u_engine (
    .clk(clk), .rst(rst), .mclr(mclr), .go(go), .cyc_force(cyc_force),
    .clr_eor(we_csr && h_wdata[CB_CLR_EOR]), .dev_cyc(dev_cyc),
    .lo_we(h_wen && (h_addr == OFS_ALO_W)),
    .hi_we(h_wen && (h_addr == OFS_AHI_W)),
    .rng_we(h_wen && (h_addr == OFS_RNG)),
    .wdata(h_wdata), .ack(dma_ack), .bus_err(dma_berr), .bus_tmo(dma_tmo),
    .active(active), .req(dma_req), .addr(dma_addr), .range(range),
    .eor(eor), .berr_f(berr_f), .tmo_f(tmo_f)
  );

  pdma_ctl #(.NF(NFN)) u_ctl (
    .clk(clk), .rst(rst), .mclr(mclr), .we_csr(we_csr),
    .fn_wr(h_wdata[CB_FN_LO +: NFN]), .ie_wr(h_wdata[CB_IE]),
    .clr_att(we_csr && h_wdata[CB_CLR_ATT]),
    .clr_par(we_csr && h_wdata[CB_CLR_PAR]),
    .go(go), .we_pls(we_pls), .pls_set(h_wdata[PB_SET_IE]),
    .pls_clr(h_wdata[PB_CLR_IE]), .attn_rise(attn_rise),
    .perr_lvl(perr_lvl), .eor(eor), .fn(dev_fn), .ie(ie), .attf(attf),
    .perr_f(perr_f), .irq(irq), .go_pulse(dev_go)
  );

  assign dma_dir = dev_fn[0];

  // data output and modifier/vector pair
  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      dev_dout <= '0;
      amv_q    <= '0;
    end else begin
      if (h_wen && (h_addr == OFS_DAT)) dev_dout <= h_wdata;
      if (h_wen && (h_addr == OFS_AMV)) amv_q    <= h_wdata;
    end
  end

  assign status = {eor, attf, attn_lvl, perr_f, stat_lvl, 1'b0,
                   !active, ie, berr_f, tmo_f, dev_fn, VARIANT_ID};

  always_comb begin
    case (h_addr)
      OFS_CSR:   rd_mux = status;
      OFS_DAT:   rd_mux = din_lvl;
      OFS_AMV:   rd_mux = amv_q;
      OFS_RNG:   rd_mux = range;
      OFS_ALO_R: rd_mux = dma_addr[W-1:0];
      OFS_AHI_R: rd_mux = dma_addr[2*W-1:W];
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) h_rdata <= '0;
    else     h_rdata <= h_ren ? rd_mux : '0;
  end
endmodule

// File: tb/test_pdma_regcore.sv
`timescale 1ns/1ps
module test_pdma_regcore;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  h_addr = '0;
  logic        h_wen = 1'b0, h_ren = 1'b0;
  logic [15:0] h_wdata = '0;
  logic [15:0] h_rdata, dev_dout;
  logic [15:0] dev_din = '0;
  logic [2:0]  dev_fn;
  logic [2:0]  dev_stat = '0;
  logic        dev_go, dev_attn = 1'b0, dev_perr = 1'b0, dev_cyc = 1'b0;
  logic        dma_req, dma_dir, irq;
  logic [31:0] dma_addr;
  logic        dma_ack = 1'b0, dma_berr = 1'b0, dma_tmo = 1'b0;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  always #10 clk = ~clk;

  pdma_regcore i_pdma_regcore (
    .clk(clk), .rst(rst), .h_addr(h_addr), .h_wen(h_wen), .h_wdata(h_wdata),
    .h_ren(h_ren), .h_rdata(h_rdata), .dev_fn(dev_fn), .dev_go(dev_go),
    .dev_dout(dev_dout), .dev_din(dev_din), .dev_attn(dev_attn),
    .dev_stat(dev_stat), .dev_perr(dev_perr), .dev_cyc(dev_cyc),
    .dma_req(dma_req), .dma_dir(dma_dir), .dma_addr(dma_addr),
    .dma_ack(dma_ack), .dma_berr(dma_berr), .dma_tmo(dma_tmo), .irq(irq)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); h_addr = a; h_wdata = d; h_wen = 1'b1;
    @(posedge clk);
    @(negedge clk); h_wen = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); h_addr = a; h_ren = 1'b1;
    @(posedge clk);
    @(negedge clk); h_ren = 1'b0; d = h_rdata;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    @(negedge clk);
  endtask

  // one device request followed by an acknowledge
  task automatic word(input bit overlap);
    @(negedge clk); dev_cyc = 1'b1;
    @(posedge clk);
    @(negedge clk); dev_cyc = overlap; dma_ack = 1'b1;
    chk("R5 request raised", dma_req, 1);
    @(posedge clk);
    @(negedge clk); dma_ack = 1'b0; dev_cyc = 1'b0;
  endtask

  task automatic ack_only();
    @(negedge clk); dma_ack = 1'b1;
    @(posedge clk);
    @(negedge clk); dma_ack = 1'b0;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cycles(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 irq", irq, 0); chk("R1 req", dma_req, 0);
    chk("R1 fn", dev_fn, 0); chk("R1 go", dev_go, 0);
    rd(6'h00, rv); chk("R1 status", rv, 16'h0081);

    // R2 / R13 sweep of function latches and interrupt enable
    for (int e = 0; e < 2; e++)
      for (int f = 0; f < 8; f++) begin
        wr(6'h00, 16'((e << 6) | (f << 1)));
        chk("R2 dev_fn", dev_fn, f);
        chk("R13 dir", dma_dir, f & 1);
        rd(6'h00, rv);
        chk("R2 status", rv, 32'h0081 | (e << 6) | (f << 1));
      end

    // R3 pulse register
    wr(6'h00, 16'h000A);
    wr(6'h06, 16'h0040); rd(6'h00, rv); chk("R3 set", rv, 16'h00CB);
    wr(6'h06, 16'h0020); rd(6'h00, rv); chk("R3 clear", rv, 16'h008B);
    wr(6'h06, 16'h0060); rd(6'h00, rv); chk("R3 both", rv, 16'h00CB);
    wr(6'h06, 16'hFF9F); rd(6'h00, rv); chk("R3 other bits", rv, 16'h00CB);
    chk("R3 fn kept", dev_fn, 5);
    rd(6'h16, rv); chk("R3 range untouched", rv, 0);

    // R4 register map
    wr(6'h14, 16'hBEEF); wr(6'h1C, 16'hCAFE); wr(6'h16, 16'h0123);
    wr(6'h04, 16'h5A3C); wr(6'h02, 16'h2468);
    dev_din = 16'h1357;
    rd(6'h18, rv); chk("R4 addr lo", rv, 16'hBEEF);
    rd(6'h20, rv); chk("R4 addr hi", rv, 16'hCAFE);
    rd(6'h16, rv); chk("R4 range", rv, 16'h0123);
    rd(6'h04, rv); chk("R4 amv", rv, 16'h5A3C);
    rd(6'h02, rv); chk("R4 din", rv, 16'h1357);
    chk("R4 dout", dev_dout, 16'h2468);
    chk("R4 dma_addr", dma_addr, 32'hCAFEBEEF);
    for (int a = 0; a < 64; a += 2) begin
      if (a != 0 && a != 2 && a != 4 && a != 'h16 && a != 'h18 && a != 'h20) begin
        rd(6'(a), rv); chk("R4 unused zero", rv, 0);
      end
    end

    // R5 / R6 / R10 DMA run with carry
    wr(6'h14, 16'hFFFC); wr(6'h1C, 16'h0001); wr(6'h16, 16'd4);
    wr(6'h00, 16'h0043);
    chk("R5 go pulse", dev_go, 1); chk("R13 dir read", dma_dir, 1);
    @(posedge clk); @(negedge clk);
    chk("R5 go one cycle", dev_go, 0);
    rd(6'h00, rv); chk("R5 busy status", rv, 16'h0043);
    for (int k = 0; k < 4; k++) begin
      word(1'b0);
      chk("R5 addr step", dma_addr, 32'h0001FFFC + 2 * (k + 1));
      chk("R6 req dropped", dma_req, 0);
      rd(6'h16, rv); chk("R5 range dec", rv, 3 - k);
    end
    rd(6'h00, rv); chk("R6 end status", rv, 16'h80C3);
    chk("R10 irq eor", irq, 1);
    rd(6'h18, rv); chk("R5 lo carry", rv, 16'h0004);
    rd(6'h20, rv); chk("R5 hi carry", rv, 16'h0002);
    wr(6'h00, 16'h8042);
    cycles(1);
    chk("R10 irq off", irq, 0);
    rd(6'h00, rv); chk("R6 clear eor", rv, 16'h00C3);

    // concurrent ack and new request; R7 forced cycle
    wr(6'h16, 16'd3); wr(6'h00, 16'h0001);
    word(1'b1);
    chk("R5 overlap keeps req", dma_req, 1);
    rd(6'h16, rv); chk("R5 overlap range", rv, 2);
    ack_only();
    chk("R5 req after ack", dma_req, 0);
    rd(6'h16, rv); chk("R5 range one", rv, 1);
    wr(6'h00, 16'h0100);
    chk("R7 forced req", dma_req, 1); chk("R13 dir write", dma_dir, 0);
    ack_only();
    rd(6'h00, rv); chk("R6 end via force", rv, 16'h8081);
    wr(6'h00, 16'h0100);
    chk("R7 idle no req", dma_req, 0);

    // R6 GO with zero range
    wr(6'h00, 16'h8000); rd(6'h00, rv); chk("R6 cleared", rv, 16'h0081);
    wr(6'h00, 16'h0001);
    rd(6'h00, rv); chk("R6 zero range go", rv, 16'h8081);

    // R11 bus error and timeout
    wr(6'h16, 16'd5); wr(6'h00, 16'h8001);
    @(negedge clk); dev_cyc = 1'b1;
    @(negedge clk); dev_cyc = 1'b0; dma_berr = 1'b1;
    @(negedge clk); dma_berr = 1'b0;
    rd(6'h00, rv); chk("R11 berr", rv, 16'h00A1);
    rd(6'h16, rv); chk("R11 range kept", rv, 5);
    chk("R11 req off", dma_req, 0);
    wr(6'h00, 16'h0001);
    @(negedge clk); dev_cyc = 1'b1;
    @(negedge clk); dev_cyc = 1'b0; dma_tmo = 1'b1;
    @(negedge clk); dma_tmo = 1'b0;
    rd(6'h00, rv); chk("R11 tmo", rv, 16'h0091);
    wr(6'h00, 16'h000B);
    rd(6'h00, rv); chk("R11 cleared by go", rv, 16'h000B);

    // R12 master clear during DMA
    wr(6'h04, 16'h7777); wr(6'h02, 16'h1111);
    wr(6'h00, 16'h104F);
    chk("R12 fn", dev_fn, 0); chk("R12 req", dma_req, 0);
    chk("R12 go ignored", dev_go, 0); chk("R12 dout", dev_dout, 0);
    rd(6'h00, rv); chk("R12 status", rv, 16'h0081);
    rd(6'h04, rv); chk("R12 amv", rv, 0);
    rd(6'h16, rv); chk("R12 range", rv, 0);
    rd(6'h18, rv); chk("R12 addr lo", rv, 0);
    rd(6'h20, rv); chk("R12 addr hi", rv, 0);

    // R8 / R10 attention and status lines
    dev_stat = 3'b101;
    wr(6'h00, 16'h0040);
    @(negedge clk); dev_attn = 1'b1;
    cycles(3);
    chk("R10 irq attn", irq, 1);
    rd(6'h00, rv); chk("R8 attn flag", rv, 16'h6AC1);
    wr(6'h00, 16'h4040);
    cycles(2);
    rd(6'h00, rv); chk("R8 held level no reset", rv, 16'h2AC1);
    @(negedge clk); dev_attn = 1'b0;
    cycles(2);
    @(negedge clk); dev_attn = 1'b1;
    @(posedge clk);
    wr(6'h00, 16'h4040);
    rd(6'h00, rv); chk("R8 edge beats clear", rv, 16'h6AC1);

    // R9 parity
    @(negedge clk); dev_perr = 1'b1;
    @(negedge clk); dev_perr = 1'b0;
    cycles(1);
    rd(6'h00, rv); chk("R9 parity set", rv, 16'h7AC1);
    wr(6'h00, 16'h2040);
    cycles(1);
    rd(6'h00, rv); chk("R9 parity clear", rv, 16'h6AC1);

    // R10 interrupt disabled through pulse register
    wr(6'h06, 16'h0020);
    cycles(1);
    chk("R10 irq gated", irq, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule